// File: doc/BRIEF.md
# SPI Master Transmit Path with Armed Data Writes

This block drives the outgoing side of an SPI master. Software writes a frame through byte-wide registers. The frame waits in a one-entry transmit buffer and moves into a shift register as soon as the shifter is free. The shifter then sends it on `sclk`/`mosi` in mode 0, most significant bit first. One `sclk` period lasts `CLK_DIV` system clocks.

A status register shows whether the buffer is empty. Software must follow a handshake before a data write counts. It first reads the status register while the empty flag is 1, and only then writes the low data byte. A low-byte write made without that armed read is dropped.

The `wide` input selects 8-bit or 16-bit frames. In 16-bit mode the high byte is staged first with its own register, and the low-byte write commits the whole word. In 8-bit mode only the low byte is sent.

Top module: `spi_tx_master`

## Requirements
- R1: After reset the status register reads 0x80 (empty flag set), and `busy`, `sclk` and `mosi` are all 0.
- R2: Address 0 is the status register, with the empty flag in bit 7 and bits 6..0 reading 0. Addresses 1, 2 and 3 read 0x00.
- R3: A write to the low data byte (address 1) that is not preceded by an arming status read is ignored. No frame is sent and the empty flag stays at 1.
- R4: A status read (`reg_rd` at address 0) taken while the empty flag is 1 arms the next low-byte write, and that write is accepted. The empty flag reads 0 in the cycle after an accepted write. A status read taken while the flag is 0 does not arm.
- R5: An accepted write disarms the handshake, so a second low-byte write without a new arming read is ignored.
- R6: When the shifter is idle and the buffer holds data, the data loads on the next clock edge. At that edge `busy` rises and the empty flag returns to 1.
- R7: Frames are sent MSB first in mode 0. `sclk` is low for the first `CLK_DIV/2` clocks of each bit and high for the rest. `mosi` holds steady while `sclk` is high. `sclk` and `mosi` are 0 while idle.
- R8: With `wide`=0 a frame is the 8 bits of the low byte. With `wide`=1 a frame is 16 bits: the high byte (address 2, written without a handshake) followed by the low byte. The mode is captured at the accepted write.
- R9: A frame waiting in the buffer when the current frame ends starts in the very next clock, and `busy` does not drop between the two frames.
- R10: `busy` stays high for exactly bits × `CLK_DIV` clocks per frame, from the shifter load until the end of the last bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wide | input | 1 | 1 selects 16-bit frames, 0 selects 8-bit frames |
| reg_addr | input | 2 | Register address: 0 status, 1 data low, 2 data high |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe; arming depends on it |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for `reg_addr` |
| sclk | output | 1 | Serial clock, idle low |
| mosi | output | 1 | Serial data out |
| busy | output | 1 | High while a frame is shifting |

## Verification
The assertions check the following on every cycle:
- the line is quiet while idle;
- `mosi` holds steady through each high `sclk` phase;
- an unarmed low-byte write leaves the empty flag set;
- the handshake is never armed while the buffer is full;
- a full buffer with an idle shifter loads on the next edge;
- each frame ends just after a high `sclk` phase.

The remaining behaviour only shows across the bench's scenarios. This covers bit order and frame content in both widths, and the exact `busy` length per frame. It also covers the gapless hand-over between buffered frames and the dropped writes in the handshake misuse cases (no read, repeated write, read while full).

// File: rtl/spi_tx_master.sv
module spi_tx_master #(
  parameter int CLK_DIV = 4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wide,
  input  logic [1:0] reg_addr,
  input  logic       reg_wr,
  input  logic       reg_rd,
  input  logic [7:0] reg_wdata,
  output logic [7:0] reg_rdata,
  output logic       sclk,
  output logic       mosi,
  output logic       busy
);
  localparam int HALF = CLK_DIV / 2;
  localparam int CW   = (CLK_DIV > 2) ? $clog2(CLK_DIV) : 1;
  localparam logic [1:0] A_STAT = 2'd0;
  localparam logic [1:0] A_LO   = 2'd1;
  localparam logic [1:0] A_HI   = 2'd2;

  logic          empty, armed;
  logic [7:0]    hi_byte;
  logic [15:0]   txbuf, shreg;
  logic          buf_wide, frame_wide;
  logic [CW-1:0] cnt;
  logic [3:0]    bitn;

  wire stat_rd   = reg_rd && reg_addr == A_STAT;
  wire accept    = reg_wr && reg_addr == A_LO && armed && empty;
  wire last_bit  = bitn == (frame_wide ? 4'd15 : 4'd7);
  wire bit_end   = busy && cnt == CW'(CLK_DIV - 1);
  wire frame_end = bit_end && last_bit;
  wire load      = !empty && (!busy || frame_end);

  assign reg_rdata = (reg_addr == A_STAT) ? {empty, 7'b0} : 8'h00;
  assign sclk      = busy && cnt >= CW'(HALF);
  assign mosi      = busy && shreg[15];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      empty    <= 1'b1;
      armed    <= 1'b0;
      hi_byte  <= '0;
      txbuf    <= '0;
      buf_wide <= 1'b0;
    end else begin
      if (reg_wr && reg_addr == A_HI) hi_byte <= reg_wdata;
      if (accept) begin
        txbuf    <= wide ? {hi_byte, reg_wdata} : {reg_wdata, 8'h00};
        buf_wide <= wide;
        empty    <= 1'b0;
        armed    <= 1'b0;
      end else if (stat_rd && empty) begin
        armed <= 1'b1;
      end
      if (load) empty <= 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shreg      <= '0;
      frame_wide <= 1'b0;
      busy       <= 1'b0;
      cnt        <= '0;
      bitn       <= '0;
    end else if (load) begin
      shreg      <= txbuf;
      frame_wide <= buf_wide;
      busy       <= 1'b1;
      cnt        <= '0;
      bitn       <= '0;
    end else if (busy) begin
      if (bit_end) begin
        cnt <= '0;
        if (last_bit) begin
          busy <= 1'b0;
        end else begin
          shreg <= {shreg[14:0], 1'b0};
          bitn  <= bitn + 4'd1;
        end
      end else begin
        cnt <= cnt + CW'(1);
      end
    end
  end
endmodule

module spi_tx_master_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       reg_wr,
  input logic [1:0] reg_addr,
  input logic       sclk,
  input logic       mosi,
  input logic       busy,
  input logic       empty,
  input logic       armed
);
  p_idle_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (!sclk && !mosi));
  p_mosi_steady_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (sclk && $past(sclk)) |-> $stable(mosi));
  p_unarmed_ignored_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_addr == 2'd1 && !armed && empty) |=> empty);
  p_no_arm_full_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !empty |-> !armed);
  p_load_when_idle_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!empty && !busy) |=> (busy && empty));
  p_end_after_high_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> $past(sclk));
endmodule

bind spi_tx_master spi_tx_master_chk u_chk (
  .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
  .sclk(sclk), .mosi(mosi), .busy(busy), .empty(empty), .armed(armed)
);

// File: tb/spi_tx_master_tb.sv
module spi_tx_master_tb;
  localparam int CLK_PERIOD = 10;
  localparam int DIV = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wide = 1'b0;
  logic [1:0] reg_addr = 2'd0;
  logic reg_wr = 1'b0, reg_rd = 1'b0;
  logic [7:0] reg_wdata = 8'h00;
  logic [7:0] reg_rdata;
  logic sclk, mosi, busy;

  int nvec = 0, nfail = 0;
  logic [63:0] cap = '0;
  int capn = 0, busycnt = 0, falls = 0;
  logic sclk_prev = 1'b0, busy_prev = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  spi_tx_master #(.CLK_DIV(DIV)) u_dut (
    .clk(clk), .rst_n(rst_n), .wide(wide), .reg_addr(reg_addr),
    .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .sclk(sclk), .mosi(mosi), .busy(busy)
  );

  always @(negedge clk) begin
    if (rst_n) begin
      if (sclk && !sclk_prev) begin
        cap  = {cap[62:0], mosi};
        capn = capn + 1;
      end
      if (busy) busycnt = busycnt + 1;
      if (busy_prev && !busy) falls = falls + 1;
    end
    sclk_prev = sclk;
    busy_prev = busy;
  end

  task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    nvec++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] v);
    @(negedge clk);
    reg_addr = a; reg_rd = 1'b1;
    #1 v = reg_rdata;
    @(negedge clk);
    reg_rd = 1'b0;
  endtask

  task automatic peek(input logic [1:0] a, output logic [7:0] v);
    reg_addr = a;
    #1 v = reg_rdata;
  endtask

  task automatic wait_idle();
    logic [7:0] v;
    for (int i = 0; i < 5000; i++) begin
      @(negedge clk);
      peek(2'd0, v);
      if (!busy && v == 8'h80) break;
    end
    @(negedge clk);
  endtask

  task automatic send(input logic w, input logic [7:0] hi, input logic [7:0] lo);
    logic [7:0] v;
    wide = w;
    if (w) wr(2'd2, hi);
    rd(2'd0, v);
    wr(2'd1, lo);
  endtask

  function automatic logic [15:0] frame_val(input logic w, input logic [7:0] hi, input logic [7:0] lo);
    return w ? {hi, lo} : {8'h00, lo};
  endfunction

  function automatic int frame_len(input logic w);
    return w ? 16 : 8;
  endfunction

  initial begin
    #(CLK_PERIOD * 150000);
    nfail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
    $finish;
  end

  initial begin
    logic [7:0] v;
    int n0, b0, f0;
    void'($urandom(32'd2024));
    repeat (3) @(negedge clk);
    peek(2'd0, v);
    check(v == 8'h80 && !busy && !sclk && !mosi, "R1 reset state", {v, busy, sclk, mosi}, {8'h80, 3'b000});
    rst_n = 1'b1;
    @(negedge clk);

    for (int a = 1; a < 4; a++) begin
      peek(2'(a), v);
      check(v == 8'h00, "R2 non-status read", v, 0);
    end
    peek(2'd0, v);
    check(v == 8'h80, "R2 status layout", v, 8'h80);

    // R3: unarmed write
    n0 = capn;
    wide = 1'b0;
    wr(2'd1, 8'h5A);
    peek(2'd0, v);
    check(v == 8'h80, "R3 flag after unarmed write", v, 8'h80);
    repeat (40) @(negedge clk);
    check(capn == n0 && !busy, "R3 no frame sent", capn - n0, 0);

    // R4/R6/R7/R8/R10 directed 8-bit
    n0 = capn; b0 = busycnt;
    rd(2'd0, v);
    wr(2'd1, 8'hA5);
    peek(2'd0, v);
    check(v == 8'h00, "R4 flag clears on accepted write", v, 8'h00);
    @(negedge clk);
    peek(2'd0, v);
    check(busy && v == 8'h80, "R6 load sets busy and empty", {busy, v}, {1'b1, 8'h80});
    wait_idle();
    check(capn - n0 == 8, "R8 8-bit length", capn - n0, 8);
    check(cap[7:0] == 8'hA5, "R7 MSB-first bits", cap[7:0], 8'hA5);
    check(busycnt - b0 == 8 * DIV, "R10 busy length", busycnt - b0, 8 * DIV);

    // R5: repeated write without new arming read
    n0 = capn;
    rd(2'd0, v);
    wr(2'd1, 8'h3C);
    wr(2'd1, 8'hFF);
    wait_idle();
    check(capn - n0 == 8 && cap[7:0] == 8'h3C, "R5 second write ignored", {capn - n0, cap[7:0]}, {32'd8, 8'h3C});

    // R4 negative: read while full does not arm
    n0 = capn;
    send(1'b0, 8'h00, 8'h11);
    send(1'b0, 8'h00, 8'h22);
    rd(2'd0, v);
    check(v == 8'h00, "R4 status while full", v, 8'h00);
    for (int i = 0; i < 500; i++) begin
      @(negedge clk);
      peek(2'd0, v);
      if (v == 8'h80) break;
    end
    wr(2'd1, 8'h44);
    wait_idle();
    check(capn - n0 == 16 && cap[15:0] == 16'h1122, "R4 read while full does not arm", {capn - n0, cap[15:0]}, {32'd16, 16'h1122});

    // R9: back-to-back 16-bit frames
    n0 = capn; b0 = busycnt; f0 = falls;
    send(1'b1, 8'hC3, 8'h81);
    send(1'b1, 8'h7E, 8'h0F);
    wait_idle();
    check(capn - n0 == 32 && cap[31:0] == 32'hC381_7E0F, "R9 buffered frame stream", cap[31:0], 32'hC3817E0F);
    check(falls - f0 == 1, "R9 no busy gap", falls - f0, 1);
    check(busycnt - b0 == 32 * DIV, "R10 back-to-back busy length", busycnt - b0, 32 * DIV);

    // Random frames
    for (int k = 0; k < 40; k++) begin
      logic w;
      logic [7:0] hi, lo;
      w = 1'($urandom % 2);
      hi = 8'($urandom);
      lo = 8'($urandom);
      n0 = capn; b0 = busycnt;
      send(w, hi, lo);
      wait_idle();
      check(capn - n0 == frame_len(w), "R8 random length", capn - n0, frame_len(w));
      check(cap[15:0] == frame_val(w, hi, lo) || (!w && cap[7:0] == lo), "R7 random bits",
            cap[15:0], frame_val(w, hi, lo));
      check(busycnt - b0 == frame_len(w) * DIV, "R10 random busy length", busycnt - b0, frame_len(w) * DIV);
    end

    $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
    $finish;
  end
endmodule